// File: doc/BRIEF.md
# Display Command and Copy Engine

This block is the command side of a memory-mapped tile display peripheral (160x128 pixels, with a 16-pixel border around the tile area) that sits beside a 16-bit processor. The processor raises a hardware-interrupt command with two 16-bit operands. The first operand selects the operation and the second carries an address. The engine keeps the video, font and palette base addresses. It tells a separate renderer when the screen may be shown.

The first time a nonzero video base is mapped, the block starts a warm-up countdown. Its length is the nominal value plus or minus about ten percent, with the offset taken from a free-running 16-bit LFSR at the moment the command arrives. The screen stays blank until the countdown ends, and it is blank at any time when the video base is zero.

Two commands dump a built-in image into system RAM: a 256-word font or a 16-word default palette. A background copier writes one word per cycle. The processor is held stalled for as many cycles as there are words to copy.

Top module: `dispctl_cmd_engine`

## Requirements
- R1: After reset, video_base, font_base and palette_base are 0, and ram_we, cpu_stall, copy_busy and disp_enable are all low.
- R2: A command with cmd_op = 0 loads cmd_arg into video_base on the accepting clock edge. While video_base is 0, disp_enable is low from the cycle after that edge.
- R3: The first op-0 command with a nonzero argument after reset loads a warm-up count D, where D = NOM - SPAN/2 + (LFSR mod SPAN). With the defaults this gives 90000 to 109999. The LFSR is 16 bits wide, free-running and never all zero. disp_enable stays low for exactly D cycles after the accepting edge.
- R4: The warm-up count falls by one every cycle until it reaches zero and is never reloaded before the next reset. If the video base is set to zero and then remapped to a nonzero value later, disp_enable rises in the cycle after the remapping edge.
- R5: cmd_op = 1 loads font_base and cmd_op = 2 loads palette_base. Any cmd_op value other than 0, 1, 2, 4 or 5 changes none of the outputs.
- R6: cmd_op = 4 writes 256 font words. Word j goes to address B+j and holds {c(2j), c(2j+1)}. The column byte is c(n) = n[7:0] XOR {8{n[8]}} XOR 8'hA5, and the first column sits in the high byte.
- R7: cmd_op = 5 writes 16 palette words. Word i goes to address B+i and is {4'h0, r, g, b}, where each 4-bit channel is 4'hA·(its bit of i: bit 2 for r, bit 1 for g, bit 0 for b) + 4'h5·i[3].
- R8: A dump asserts ram_we for exactly N consecutive cycles, starting in the cycle after the accepting edge, with one word per cycle. The address wraps modulo 65536.
- R9: cpu_stall is high for exactly the same N cycles as copy_busy.
- R10: A dump command that arrives while copy_busy is high is ignored, and the copy in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 16 | Operation code (first operand) |
| cmd_arg | input | 16 | Address operand (second operand) |
| ram_we | output | 1 | System RAM write enable |
| ram_addr | output | 16 | System RAM write address |
| ram_wdata | output | 16 | System RAM write data |
| cpu_stall | output | 1 | Holds the processor while a dump is charged |
| copy_busy | output | 1 | Copy in progress |
| disp_enable | output | 1 | Renderer may show the screen |
| video_base | output | 16 | Current video base address |
| font_base | output | 16 | Current font base address |
| palette_base | output | 16 | Current palette base address |

## Verification
The assertions assume that cmd_valid is a single-cycle strobe and that the reset is held for at least one edge. The stall and busy properties also assume that the processor issues no dump while it is stalled, apart from the one deliberate overlapping command. The bench drives each command for exactly one cycle, on the falling edge. The only dump it sends during a copy is that deliberate overlap, and it is timed to land in the middle of a font copy, so the ignore rule of R10 is exercised without breaking the single-strobe assumption.

// File: rtl/dispctl_pkg.sv
package dispctl_pkg;
   localparam int WORD_W = 16;

   localparam logic [WORD_W-1:0] OP_MAP       = 16'd0;
   localparam logic [WORD_W-1:0] OP_FONT_BASE = 16'd1;
   localparam logic [WORD_W-1:0] OP_PAL_BASE  = 16'd2;
   localparam logic [WORD_W-1:0] OP_FONT_DUMP = 16'd4;
   localparam logic [WORD_W-1:0] OP_PAL_DUMP  = 16'd5;

   typedef enum logic {CP_IDLE = 1'b0, CP_COPY = 1'b1} copy_state_t;

   // one 8-bit glyph column, indexed over the flat column stream
   function automatic logic [7:0] glyph_col(input logic [16:0] n);
      return n[7:0] ^ {8{n[8]}} ^ 8'hA5;
   endfunction

   function automatic logic [WORD_W-1:0] font_word(input logic [15:0] k);
      logic [16:0] n0;
      n0 = {k, 1'b0};
      return {glyph_col(n0), glyph_col(n0 | 17'd1)};
   endfunction

   function automatic logic [WORD_W-1:0] pal_word(input logic [3:0] i);
      logic [3:0] lo, r, g, b;
      lo = i[3] ? 4'h5 : 4'h0;
      r  = (i[2] ? 4'hA : 4'h0) + lo;
      g  = (i[1] ? 4'hA : 4'h0) + lo;
      b  = (i[0] ? 4'hA : 4'h0) + lo;
      return {4'h0, r, g, b};
   endfunction
endpackage

// File: rtl/dispctl_rom.sv
module dispctl_rom
   import dispctl_pkg::*;
#(
   parameter int IDX_W = 9
) (
   input  logic              sel_font,
   input  logic [IDX_W-1:0]  idx,
   output logic [WORD_W-1:0] word
);
   generate
      if (IDX_W > 16) begin : g_bad
         $error("dispctl_rom: IDX_W must not exceed 16");
      end
   endgenerate

   always_comb begin
      if (sel_font) word = font_word(16'(idx));
      else          word = pal_word(idx[3:0]);
   end
endmodule

// File: rtl/dispctl_powerup.sv
module dispctl_powerup #(
   parameter int NOM       = 100000,
   parameter int SPAN      = 20000,
   parameter logic [15:0] SEED = 16'hACE1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic map_cmd,
   input  logic map_nonzero,
   input  logic vb_nonzero,
   output logic disp_enable
);
   localparam int CNT_W = $clog2(NOM + SPAN + 1);
   localparam int BASE  = NOM - SPAN / 2;

   generate
      if (SPAN / 2 > NOM) begin : g_bad_span
         $error("dispctl_powerup: SPAN/2 must not exceed NOM");
      end
      if (SPAN > 65535) begin : g_bad_wide
         $error("dispctl_powerup: SPAN must fit in 16 bits");
      end
   endgenerate

   logic [CNT_W-1:0] count;
   logic [CNT_W-1:0] delay;
   logic             activated;

   generate
      if (SPAN > 0) begin : g_jitter
         logic [15:0] lfsr;
         logic [15:0] jit;
         always_ff @(posedge clk) begin
            if (!rst_n) lfsr <= SEED;
            else        lfsr <= {1'b0, lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
         end
         assign jit   = lfsr % 16'(SPAN);
         assign delay = CNT_W'(BASE) + CNT_W'(jit);
      end else begin : g_fixed
         assign delay = CNT_W'(NOM);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         activated <= 1'b0;
         count     <= '0;
      end else if (map_cmd && map_nonzero && !activated) begin
         activated <= 1'b1;
         count     <= delay;
      end else if (count != '0) begin
         count <= count - 1'b1;
      end
   end

   assign disp_enable = activated && (count == '0) && vb_nonzero;

   // R4
   countdown_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count != '0) |=> (count == $past(count) - 1'b1));
   // R4
   activated_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      activated |=> activated);
   // R3
   blank_in_warmup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      disp_enable |-> (count == '0 && activated));
endmodule

// File: rtl/dispctl_copier.sv
module dispctl_copier
   import dispctl_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int IDX_W  = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              start_font,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [IDX_W-1:0]  start_len,
   output logic              busy,
   output logic              sel_font,
   output logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] dst
);
   copy_state_t      state;
   logic [IDX_W-1:0] left;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= CP_IDLE;
         dst      <= '0;
         idx      <= '0;
         left     <= '0;
         sel_font <= 1'b0;
      end else begin
         case (state)
            CP_IDLE: if (start && start_len != '0) begin
               state    <= CP_COPY;
               dst      <= start_addr;
               idx      <= '0;
               left     <= start_len;
               sel_font <= start_font;
            end
            CP_COPY: begin
               dst  <= dst + 1'b1;
               idx  <= idx + 1'b1;
               left <= left - 1'b1;
               if (left == IDX_W'(1)) state <= CP_IDLE;
            end
            default: state <= CP_IDLE;
         endcase
      end
   end

   assign busy = (state == CP_COPY);

   // R8
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> (dst == $past(dst) + 1'b1));
   // R8
   copy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (left != '0 && idx == '0));
endmodule

// File: rtl/dispctl_stall.sv
module dispctl_stall #(
   parameter int IDX_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             charge,
   input  logic [IDX_W-1:0] amount,
   output logic             stall
);
   logic [IDX_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)               cnt <= '0;
      else if (charge)          cnt <= amount;
      else if (cnt != '0)       cnt <= cnt - 1'b1;
   end

   assign stall = (cnt != '0);

   // R9
   stall_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && !charge) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/dispctl_cmd_engine.sv
module dispctl_cmd_engine
   import dispctl_pkg::*;
#(
   parameter int NOM        = 100000,
   parameter int SPAN       = 20000,
   parameter int FONT_WORDS = 256,
   parameter int PAL_WORDS  = 16,
   parameter logic [15:0] SEED = 16'hACE1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd_valid,
   input  logic [15:0] cmd_op,
   input  logic [15:0] cmd_arg,
   output logic        ram_we,
   output logic [15:0] ram_addr,
   output logic [15:0] ram_wdata,
   output logic        cpu_stall,
   output logic        copy_busy,
   output logic        disp_enable,
   output logic [15:0] video_base,
   output logic [15:0] font_base,
   output logic [15:0] palette_base
);
   localparam int IDX_W = $clog2(FONT_WORDS + 1);

   generate
      if (PAL_WORDS > FONT_WORDS || PAL_WORDS > 16 || PAL_WORDS < 1) begin : g_bad_pal
         $error("dispctl_cmd_engine: PAL_WORDS must be 1..16 and not above FONT_WORDS");
      end
      if (FONT_WORDS < 1 || FONT_WORDS > 65535) begin : g_bad_font
         $error("dispctl_cmd_engine: FONT_WORDS out of range");
      end
   endgenerate

   logic             is_map, is_dump, is_font_dump, start;
   logic [IDX_W-1:0] dump_len;
   logic             sel_font;
   logic [IDX_W-1:0] idx;

   assign is_map       = cmd_valid && (cmd_op == OP_MAP);
   assign is_font_dump = (cmd_op == OP_FONT_DUMP);
   assign is_dump      = cmd_valid && (is_font_dump || cmd_op == OP_PAL_DUMP);
   assign start        = is_dump && !copy_busy;
   assign dump_len     = is_font_dump ? IDX_W'(FONT_WORDS) : IDX_W'(PAL_WORDS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         video_base   <= '0;
         font_base    <= '0;
         palette_base <= '0;
      end else if (cmd_valid) begin
         case (cmd_op)
            OP_MAP:       video_base   <= cmd_arg;
            OP_FONT_BASE: font_base    <= cmd_arg;
            OP_PAL_BASE:  palette_base <= cmd_arg;
            default: ;
         endcase
      end
   end

   dispctl_powerup #(.NOM(NOM), .SPAN(SPAN), .SEED(SEED)) u_pwr (
      .clk         (clk),
      .rst_n       (rst_n),
      .map_cmd     (is_map),
      .map_nonzero (cmd_arg != 16'h0),
      .vb_nonzero  (video_base != 16'h0),
      .disp_enable (disp_enable)
   );

   dispctl_copier #(.ADDR_W(16), .IDX_W(IDX_W)) u_copy (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .start_font (is_font_dump),
      .start_addr (cmd_arg),
      .start_len  (dump_len),
      .busy       (copy_busy),
      .sel_font   (sel_font),
      .idx        (idx),
      .dst        (ram_addr)
   );

   dispctl_rom #(.IDX_W(IDX_W)) u_rom (
      .sel_font (sel_font),
      .idx      (idx),
      .word     (ram_wdata)
   );

   dispctl_stall #(.IDX_W(IDX_W)) u_stall (
      .clk    (clk),
      .rst_n  (rst_n),
      .charge (start),
      .amount (dump_len),
      .stall  (cpu_stall)
   );

   assign ram_we = copy_busy;

   // R9
   stall_busy_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_stall == copy_busy);
   // R10
   dump_ignored_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (copy_busy && is_dump) |=> (ram_addr == $past(ram_addr) + 16'd1));
   // R2
   blank_when_unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (video_base == 16'h0) |-> !disp_enable);
endmodule

// File: tb/sim_dispctl_cmd_engine.sv
`timescale 1ns/1ps
module sim_dispctl_cmd_engine;
   localparam int NOM  = 40;
   localparam int SPAN = 8;
   localparam int FW   = 256;
   localparam int PW   = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [15:0] cmd_op = '0, cmd_arg = '0;
   logic        ram_we, cpu_stall, copy_busy, disp_enable;
   logic [15:0] ram_addr, ram_wdata, video_base, font_base, palette_base;

   int checks = 0, failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   dispctl_cmd_engine #(.NOM(NOM), .SPAN(SPAN), .FONT_WORDS(FW), .PAL_WORDS(PW)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
      .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata), .cpu_stall(cpu_stall),
      .copy_busy(copy_busy), .disp_enable(disp_enable), .video_base(video_base),
      .font_base(font_base), .palette_base(palette_base));

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] col_byte(input int n);
      logic [8:0] v;
      v = 9'(n);
      return v[7:0] ^ {8{v[8]}} ^ 8'hA5;
   endfunction

   function automatic logic [15:0] exp_font(input int j);
      return {col_byte(2 * j), col_byte(2 * j + 1)};
   endfunction

   function automatic logic [15:0] exp_pal(input int i);
      int lo;
      lo = ((i >> 3) & 1) * 5;
      return 16'((((i >> 2) & 1) * 10 + lo) << 8 | (((i >> 1) & 1) * 10 + lo) << 4
                 | ((i & 1) * 10 + lo));
   endfunction

   task automatic issue(input logic [15:0] op, input logic [15:0] arg);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 16'hFFFF; cmd_arg = 16'h0;
   endtask

   task automatic do_reset(input int extra);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (extra) @(negedge clk);
   endtask

   // after issue(): the negedge following the accepting edge
   task automatic warmup_measure(input logic [15:0] arg);
      int k;
      issue(16'h0000, arg);
      k = 0;
      while (!disp_enable && k < 500) begin
         k++;
         @(negedge clk);
      end
      // R3: blank for D cycles, D in range
      check(k >= NOM - SPAN / 2 && k <= NOM - SPAN / 2 + SPAN - 1, "R3 warm-up length",
            k, NOM);
      check(video_base == arg, "R2 video base", video_base, arg);
   endtask

   task automatic run_dump(input logic [15:0] op, input logic [15:0] base, input int n,
                           input bit font, input bit poke);
      issue(op, base);
      for (int j = 0; j < n; j++) begin
         check(ram_we === 1'b1, "R8 write enable", ram_we, 1);
         check(ram_addr == 16'(base + j), "R8 address wrap", ram_addr, 16'(base + j));
         if (font) check(ram_wdata == exp_font(j), "R6 font word", ram_wdata, exp_font(j));
         else      check(ram_wdata == exp_pal(j), "R7 palette word", ram_wdata, exp_pal(j));
         check(cpu_stall === 1'b1 && copy_busy === 1'b1, "R9 stall during copy", cpu_stall, 1);
         if (poke && j == 5) begin
            // R10: a palette dump lands mid-copy
            cmd_valid = 1'b1; cmd_op = 16'h0005; cmd_arg = 16'h1234;
         end else begin
            cmd_valid = 1'b0; cmd_op = 16'hFFFF; cmd_arg = 16'h0;
         end
         @(negedge clk);
      end
      cmd_valid = 1'b0;
      check(ram_we === 1'b0 && copy_busy === 1'b0, "R8 copy ends after N", ram_we, 0);
      check(cpu_stall === 1'b0, "R9 stall released", cpu_stall, 0);
      if (poke) begin
         @(negedge clk);
         check(ram_we === 1'b0, "R10 ignored dump never starts", ram_we, 0);
      end
   endtask

   initial begin
      cmd_op = 16'hFFFF;
      do_reset(1);
      // R1 reset state
      check(video_base == 0 && font_base == 0 && palette_base == 0, "R1 bases", video_base, 0);
      check({ram_we, cpu_stall, copy_busy, disp_enable} == 4'b0, "R1 flags",
            {ram_we, cpu_stall, copy_busy, disp_enable}, 0);

      // R5 base registers and unknown ops
      issue(16'h0001, 16'h4400);
      check(font_base == 16'h4400, "R5 font base", font_base, 16'h4400);
      issue(16'h0002, 16'h5500);
      check(palette_base == 16'h5500, "R5 palette base", palette_base, 16'h5500);
      for (int op = 3; op < 12; op++) begin
         if (op == 4 || op == 5) continue;
         issue(16'(op), 16'hBEEF);
         check(video_base == 0 && font_base == 16'h4400 && palette_base == 16'h5500
               && !ram_we && !cpu_stall, "R5 unknown op ignored", op, 0);
      end
      // R2: mapping zero keeps the display blank and does not activate
      issue(16'h0000, 16'h0000);
      repeat (NOM + SPAN) @(negedge clk);
      check(disp_enable === 1'b0, "R2 zero base blank", disp_enable, 0);

      warmup_measure(16'h8000);
      // R4: disconnect then remap, no second warm-up
      issue(16'h0000, 16'h0000);
      check(disp_enable === 1'b0, "R2 blank on disconnect", disp_enable, 0);
      issue(16'h0000, 16'h9000);
      check(disp_enable === 1'b1, "R4 remap enables at once", disp_enable, 1);

      // R6/R8/R9 font dump with wrap, R10 overlapping command
      run_dump(16'h0004, 16'hFFF8, FW, 1'b1, 1'b1);
      // R7 palette dump
      run_dump(16'h0005, 16'h0100, PW, 1'b0, 1'b0);
      run_dump(16'h0005, 16'hFFFF, PW, 1'b0, 1'b0);

      // R3 with other LFSR samples
      for (int w = 0; w < 6; w++) begin
         do_reset(w * 7 + 3);
         warmup_measure(16'(16'h0100 + w));
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=0x0 expected=0x1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule